// File: doc/BRIEF.md
# Interrupt status and mask controller

This block gathers interrupt events from peripherals into a latched status register and holds a mask that software writes. It raises one interrupt request toward the processor whenever a status bit is set and its mask bit is also set. Software services an interrupt by writing ones to the status register. Each one clears the matching bit, and each zero leaves its bit alone.

The block has its own frame timer. This is a free-running divider that sets the vertical-blank status bit once every `FRAME_CYCLES` clocks, which is the processor clock rate divided by the frame rate. Each source bit is either edge-qualified or level-qualified, chosen by a parameter mask. An edge-qualified bit is set once per rising edge of its input. A level-qualified bit is set again on every cycle its input stays high.

Both registers are reached over a simple single-cycle register bus with a byte address. The status register is at offset 0 and the mask at offset 4. Read data and the error flag appear one clock after the access.

Top module: `intc_top`

## Requirements
- R1: A read at byte offset 0 returns the status register and a read at offset 4 returns the mask. The value is zero-extended to 32 bits and appears on `bus_rdata` in the cycle after the access, with `bus_err` low.
- R2: A write to offset 0 clears each implemented status bit that is 1 in the write data. Status bits written as 0, and write data bits at or above `NUM_SRC`, have no effect.
- R3: A write to offset 4 replaces the mask with the low `NUM_SRC` bits of the write data. Higher bits are dropped and read back as zero.
- R4: `irq` is high exactly when some bit is set in both status and mask. It follows the registers in the cycle after the edge that changes them.
- R5: A source event on bit i sets status bit i at the next clock edge. The bit then stays set until software clears it.
- R6: If a source event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: A bit with a 1 in `EDGE_MASK` is set only on a rising edge of its input, so clearing it while its input stays high leaves it clear. A bit with a 0 is set on every cycle its input is high, so clearing it while its input stays high does not take.
- R8: The frame timer sets status bit `VSYNC_BIT` once every `FRAME_CYCLES` clocks. With that bit unmasked, successive rises of `irq` are exactly `FRAME_CYCLES` cycles apart when the bit is cleared in between.
- R9: Any access at offsets 1, 2, 3, 5, 6 or 7 raises `bus_err` in the following cycle with `bus_rdata` zero. Such a write changes neither status nor mask.
- R10: After reset, status and mask are zero, and `irq`, `bus_err` and `bus_rdata` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Interrupt source inputs, one per status bit |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Illegal offset flag, the cycle after the access |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A source event and a status-clearing write can land on the same bit in the same clock. The bench drives a pulse and an acknowledge write for one bit in the same cycle, then reads back status and expects the bit still set. A second collision keeps an input high while its bit is cleared. There the bench expects an edge-qualified bit to stay clear and a level-qualified bit to be set again, and it judges both by a later read and by `irq`.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned BUS_DW = 32;

    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_MASK   = 4;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_BAD    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
    parameter int unsigned        NUM_SRC   = 11,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] set_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
    } cond_state_t;

    cond_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        if (EDGE_MASK[g]) begin : g_edge
            assign set_o[g] = src_i[g] & ~st_q.prev[g];

            // R7: an edge-qualified bit never produces two set events back to back
            assert_edge_single_R7 : assert property (@(posedge clk) disable iff (!rst_n)
                set_o[g] |=> !set_o[g]);
        end else begin : g_level
            assign set_o[g] = src_i[g];
        end
    end

endmodule

// File: rtl/intc_frame_timer.sv
module intc_frame_timer #(
    parameter int unsigned FRAME_CYCLES = 564480
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int unsigned CNT_W = (FRAME_CYCLES > 2) ? $clog2(FRAME_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    assign tick_o = (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: the counter restarts right after each frame tick
    assert_tick_restart_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (st_q.cnt == '0) && !tick_o);

    initial begin
        assert (FRAME_CYCLES >= 2) else $error("FRAME_CYCLES must be at least 2");
    end

endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 11,
    parameter int unsigned ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    output logic               bus_err,
    output logic [NUM_SRC-1:0] status_o,
    output logic               irq_o
);

    localparam int unsigned PAD_W = BUS_DW - NUM_SRC;

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] mask;
        logic [BUS_DW-1:0]  rdata;
        logic               err;
    } regs_state_t;

    regs_state_t st_d, st_q;
    reg_sel_e    sel;
    logic        wr_status;
    logic        wr_mask;
    logic [NUM_SRC-1:0] wdata_low;
    logic [PAD_W-1:0]   unused_wdata_hi;

    assign wdata_low       = bus_wdata[NUM_SRC-1:0];
    assign unused_wdata_hi = bus_wdata[BUS_DW-1:NUM_SRC];

    always_comb begin
        if (!bus_sel) begin
            sel = SEL_NONE;
        end else if (bus_addr == ADDR_W'(OFS_STATUS)) begin
            sel = SEL_STATUS;
        end else if (bus_addr == ADDR_W'(OFS_MASK)) begin
            sel = SEL_MASK;
        end else begin
            sel = SEL_BAD;
        end
    end

    assign wr_status = bus_wr && (sel == SEL_STATUS);
    assign wr_mask   = bus_wr && (sel == SEL_MASK);

    always_comb begin
        st_d = st_q;
        // acknowledge first, then sources, so a same-cycle event survives
        if (wr_status) begin
            st_d.status = st_q.status & ~wdata_low;
        end
        st_d.status = st_d.status | set_i;
        if (wr_mask) begin
            st_d.mask = wdata_low;
        end
        st_d.rdata = '0;
        if (!bus_wr) begin
            case (sel)
                SEL_STATUS: st_d.rdata = {{PAD_W{1'b0}}, st_q.status};
                SEL_MASK:   st_d.rdata = {{PAD_W{1'b0}}, st_q.mask};
                default:    st_d.rdata = '0;
            endcase
        end
        st_d.err = (sel == SEL_BAD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign bus_err   = st_q.err;
    assign status_o  = st_q.status;
    assign irq_o     = |(st_q.status & st_q.mask);

    // R2: an acknowledge with no competing event clears exactly the written ones
    assert_ack_clears_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && (set_i == '0)) |=>
            (st_q.status == ($past(st_q.status) & ~$past(wdata_low))));

    // R3: a mask write loads the low bits of the write data
    assert_mask_load_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (st_q.mask == $past(wdata_low)));

    // R6: every bit hit by a source event is set afterwards, whatever was written
    assert_set_wins_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((st_q.status & $past(set_i)) == $past(set_i)));

    // R9: a bad offset flags an error and leaves the mask untouched
    assert_bad_offset_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_BAD) |=> (bus_err && (bus_rdata == '0) && $stable(st_q.mask)));

    initial begin
        assert (NUM_SRC < BUS_DW && ADDR_W >= 3) else $error("bad intc_regs parameters");
    end

endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int unsigned        NUM_SRC      = 11,
    parameter int unsigned        ADDR_W       = 3,
    parameter int unsigned        FRAME_CYCLES = 564480,
    parameter int unsigned        VSYNC_BIT    = 0,
    parameter logic [NUM_SRC-1:0] EDGE_MASK    = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_err,
    output logic               irq
);

    logic               frame_tick;
    logic [NUM_SRC-1:0] cond_set;
    logic [NUM_SRC-1:0] all_set;
    logic [NUM_SRC-1:0] status;

    intc_src_cond #(
        .NUM_SRC   (NUM_SRC),
        .EDGE_MASK (EDGE_MASK)
    ) i_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_in),
        .set_o (cond_set)
    );

    intc_frame_timer #(
        .FRAME_CYCLES (FRAME_CYCLES)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (frame_tick)
    );

    always_comb begin
        all_set            = cond_set;
        all_set[VSYNC_BIT] = cond_set[VSYNC_BIT] | frame_tick;
    end

    intc_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (all_set),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .status_o  (status),
        .irq_o     (irq)
    );

    // R8: each frame tick leaves the vertical-blank status bit set
    assert_vsync_sets_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> status[VSYNC_BIT]);

    // R10: first cycle out of reset has no request and no error
    assert_reset_quiet_R10 : assert property (@(posedge clk)
        !rst_n |=> (!irq && !bus_err && (bus_rdata == '0)));

endmodule

// File: tb/test_intc_top.sv
`timescale 1ns/1ps
module test_intc_top;

    localparam int unsigned NSRC   = 11;
    localparam int unsigned FRAME  = 200;
    localparam logic [NSRC-1:0] EMASK = 11'b000_0011_1111;
    localparam logic [31:0] IGN0 = 32'h0000_07FE;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src_in = '0;
    logic             bus_sel = 1'b0;
    logic             bus_wr = 1'b0;
    logic [2:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             bus_err;
    logic             irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    intc_top #(
        .NUM_SRC      (NSRC),
        .ADDR_W       (3),
        .FRAME_CYCLES (FRAME),
        .VSYNC_BIT    (0),
        .EDGE_MASK    (EMASK)
    ) i_intc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
        e = bus_err;
    endtask

    task automatic pulse(input logic [NSRC-1:0] bits);
        @(negedge clk);
        src_in = bits;
        @(negedge clk);
        src_in = '0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        logic        e;
        logic [31:0] expv;
        int t1;
        int t2;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 irq", {31'b0, irq}, 32'h0);
        check("R10 err", {31'b0, bus_err}, 32'h0);
        check("R10 rdata", bus_rdata, 32'h0);
        rd(3'd0, d, e);
        check("R10 status", d & IGN0, 32'h0);
        rd(3'd4, d, e);
        check("R10 mask", d, 32'h0);
        check("R1 err on legal read", {31'b0, e}, 32'h0);

        // R5 R2 R1: each source bit sets and is cleared alone
        for (int i = 1; i < NSRC; i++) begin
            pulse(NSRC'(1) << i);
            rd(3'd0, d, e);
            check("R5 set bit", d & IGN0, 32'h1 << i);
            wr(3'd0, 32'h1 << i);
            rd(3'd0, d, e);
            check("R2 clear bit", d & IGN0, 32'h0);
        end

        // R2: partial acknowledge, upper data bits ignored
        pulse(11'h7FE);
        wr(3'd0, 32'h0000_00AA);
        rd(3'd0, d, e);
        check("R2 partial", d & IGN0, 32'h0000_0754);
        wr(3'd0, 32'hFFFF_F800);
        rd(3'd0, d, e);
        check("R2 upper ignored", d & IGN0, 32'h0000_0754);
        wr(3'd0, 32'h0000_07FE);
        rd(3'd0, d, e);
        check("R2 full clear", d & IGN0, 32'h0);

        // R3 R4: mask sweep with irq response
        for (int i = 1; i < NSRC; i++) begin
            int j;
            j = (i % (NSRC - 1)) + 1;
            wr(3'd4, 32'hFFFF_F800 | (32'h1 << i));
            rd(3'd4, d, e);
            check("R3 mask readback", d, 32'h1 << i);
            pulse(NSRC'(1) << j);
            check("R4 masked bit no irq", {31'b0, irq}, 32'h0);
            pulse(NSRC'(1) << i);
            check("R4 unmasked bit irq", {31'b0, irq}, 32'h1);
            wr(3'd0, 32'h1 << i);
            check("R4 irq drops on ack", {31'b0, irq}, 32'h0);
            wr(3'd0, 32'h1 << j);
        end
        wr(3'd4, 32'h0);

        // R6: pulse and acknowledge on bit 3 in one cycle
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h8;
        src_in = 11'h008;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; src_in = '0;
        rd(3'd0, d, e);
        check("R6 set wins", d & IGN0, 32'h8);
        wr(3'd0, 32'h8);

        // R7: held inputs, edge bit 2 versus level bit 7
        wr(3'd4, 32'h0000_0084);
        @(negedge clk);
        src_in = 11'h084;
        repeat (3) @(negedge clk);
        wr(3'd0, 32'h0000_0084);
        rd(3'd0, d, e);
        check("R7 edge/level while held", d & IGN0, 32'h0000_0080);
        check("R7 irq from level bit", {31'b0, irq}, 32'h1);
        @(negedge clk);
        src_in = '0;
        wr(3'd0, 32'h0000_0084);
        rd(3'd0, d, e);
        check("R7 cleared after release", d & IGN0, 32'h0);
        check("R7 irq low after release", {31'b0, irq}, 32'h0);

        // R9: every illegal offset, read and write
        wr(3'd4, 32'h0000_02AA);
        pulse(11'h154);
        for (int k = 1; k < 8; k++) begin
            if (k != 4) begin
                wr(3'(k), 32'hFFFF_FFFF);
                rd(3'(k), d, e);
                check("R9 bad read data", d, 32'h0);
                check("R9 bad read err", {31'b0, e}, 32'h1);
            end
        end
        rd(3'd4, d, e);
        check("R9 mask untouched", d, 32'h0000_02AA);
        check("R1 err low on good read", {31'b0, e}, 32'h0);
        rd(3'd0, d, e);
        expv = 32'h0000_0154;
        check("R9 status untouched", d & IGN0, expv);
        check("R4 disjoint mask", {31'b0, irq}, 32'h0);
        wr(3'd0, 32'h0000_07FE);
        wr(3'd4, 32'h0);

        // R8: frame period measured between irq rises
        wr(3'd4, 32'h1);
        wr(3'd0, 32'h1);
        while (!irq) @(negedge clk);
        t1 = cyc;
        wr(3'd0, 32'h1);
        check("R8 cleared", {31'b0, irq}, 32'h0);
        while (!irq) @(negedge clk);
        t2 = cyc;
        check("R8 period", 32'(t2 - t1), 32'(FRAME));
        wr(3'd0, 32'h1);
        while (!irq) @(negedge clk);
        t1 = cyc;
        check("R8 second period", 32'(t1 - t2), 32'(FRAME));
        rd(3'd0, d, e);
        check("R1 vsync visible in status", d & 32'h1, 32'h1);

        done = 1'b1;
        finish_run();
    end

endmodule